// File: doc/BRIEF.md
# PLL Mode-Control Power-Up Sequencer

This block owns the three control pins of an analog phase locked loop: an output gate, an active-low bypass control and an active-low reset. Software drives it through a small register port. A write that asks for all three controls starts a timed power-up walk. The walk first takes the loop out of bypass. It then holds for a minimum gap before releasing reset. After that it waits a fixed settling time and for the loop's lock indication before it opens the output gate. A write that asks for none of the controls shuts all three pins off in a single step.

A hardware vote mode can be selected in the mode register. While it is selected, software control writes have no effect on the pins. A vote input raises and lowers the loop instead. In this mode the gap and the settling wait come from two 6-bit count fields, counted in microseconds. Software normally programs the bias count to 1 and the lock count to 0. A separate mode bit holds the vote machine idle. A status bit reports that the output stage has been reached. A watcher flags a timeout when a vote stays unanswered for longer than the polling budget of a waiting requester.

All delays come from one parameter, the number of clock cycles per microsecond. The loop itself sits outside the block and is seen only through its lock input.

Top module: `pll_pwrup_seq`

## Requirements
- R1: After reset, pll_outen, pll_bypass_n, pll_reset_n, pll_up and vote_timeout are all low, and both readable addresses return zero.
- R2: A write to address 0 with bits 2:0 = 111 and bit 20 = 0, made while all three pins are low, has the following effect. pll_bypass_n rises the cycle after the write. pll_reset_n rises GAP_US*TICKS_PER_US cycles after pll_bypass_n. pll_outen rises at the first clock edge that is at least LOCK_US*TICKS_PER_US cycles after pll_reset_n and at which pll_lock is high.
- R3: pll_up rises together with pll_outen at the end of a sequence. It stays high until a disable, and it falls in the same cycle as the output gate.
- R4: An enable write made while any of the three pins is already high neither restarts nor shifts the sequence. A write whose bits 2:0 are neither 111 nor 000 changes no pin.
- R5: A write to address 0 with bits 2:0 = 000 and bit 20 = 0 drives all three pins low in the cycle after the write, from any state. This also holds when the same edge would have completed a sequence step.
- R6: A mode write with bit 20 = 1 leaves the pins as they are, whatever bits 2:0 hold. While bit 20 is clear, vote_req has no effect.
- R7: With vote mode stored, vote_req high starts the same walk. The bypass-to-reset gap is bias_count*TICKS_PER_US cycles, where bias_count is bits 19:14. The settling wait is lock_count*TICKS_PER_US cycles, where lock_count is bits 13:8. A count of zero means one cycle.
- R8: In vote mode, dropping vote_req once the output is on clears pll_outen and pll_up first and pll_reset_n and pll_bypass_n one cycle later. Dropping vote_req before the output is on clears every pin in the next cycle.
- R9: While mode bit 21 is set in vote mode, the sequencer stays idle with all pins low. Setting that bit mid-sequence returns the sequencer to idle, and the setting takes effect one edge after the write.
- R10: In vote mode with bit 21 clear, vote_timeout rises once vote_req has been high and pll_up low for POLL_LIMIT*TICKS_PER_US consecutive cycles. It clears in the cycle after vote_req drops.
- R11: Readback at address 0 gives bit 0 = pll_outen, bit 1 = pll_bypass_n, bit 2 = pll_reset_n, bits 13:8 = lock count, bits 19:14 = bias count, bit 20 = vote enable and bit 21 = vote hold, with all other bits zero. Address 1 gives bit 0 = pll_up and bit 1 = vote_timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mode register, 1 the status register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| vote_req | input | 1 | Hardware vote, used only in vote mode |
| pll_lock | input | 1 | Lock indication from the loop |
| pll_outen | output | 1 | Output gate enable |
| pll_bypass_n | output | 1 | Bypass control, high means not bypassed |
| pll_reset_n | output | 1 | Loop reset, high means released |
| pll_up | output | 1 | Status: sequence reached the output stage |
| vote_timeout | output | 1 | Vote unanswered within the polling budget |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a software disable write coincides with the edge at which lock and the settling timer together would open the output. The bench times the write for exactly that edge and requires all pins and status to be low afterwards. In the second, a mode write that sets the vote-hold bit arrives while a vote sequence is counting its gap. The bench expects the write to land on the old setting for that edge and to stop the walk on the next one. Random runs mix late lock arrival with random bias and lock counts and compare the measured edge positions with values computed from the requirement formulas.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  // field positions in the mode word (software decodes these)
  localparam int FLD_W      = 6;
  localparam int B_OUT      = 0;
  localparam int B_BYPN     = 1;
  localparam int B_RSTN     = 2;
  localparam int B_LCK_LSB  = 8;
  localparam int B_BIAS_LSB = 14;
  localparam int B_VEN      = 20;
  localparam int B_VRST     = 21;
  localparam int MODE_TOP   = B_VRST;
  localparam int FLD_MAX    = (1 << FLD_W) - 1;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_BYPASS,
    SEQ_RELEASE,
    SEQ_ON,
    SEQ_DRAIN
  } seq_state_e;

  typedef struct packed {
    logic             vrst;
    logic             ven;
    logic [FLD_W-1:0] bias;
    logic [FLD_W-1:0] lock;
  } mode_cfg_t;
endpackage

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              outen,
  input  logic              bypass_n,
  input  logic              reset_n,
  input  logic              up,
  input  logic              timeout,
  output mode_cfg_t         cfg,
  output logic              sw_on,
  output logic              sw_off,
  output logic [DATA_W-1:0] rdata
);
  logic       mode_wr;
  logic [2:0] ctl;

  assign mode_wr = wr && !addr;
  assign ctl     = wdata[B_RSTN:B_OUT];
  // the vote bit of the same word gates software control
  assign sw_on   = mode_wr && !wdata[B_VEN] && (ctl == 3'b111);
  assign sw_off  = mode_wr && !wdata[B_VEN] && (ctl == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (mode_wr) begin
      cfg.lock <= wdata[B_LCK_LSB +: FLD_W];
      cfg.bias <= wdata[B_BIAS_LSB +: FLD_W];
      cfg.ven  <= wdata[B_VEN];
      cfg.vrst <= wdata[B_VRST];
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[B_OUT]               = outen;
      rdata[B_BYPN]              = bypass_n;
      rdata[B_RSTN]              = reset_n;
      rdata[B_LCK_LSB +: FLD_W]  = cfg.lock;
      rdata[B_BIAS_LSB +: FLD_W] = cfg.bias;
      rdata[B_VEN]               = cfg.ven;
      rdata[B_VRST]              = cfg.vrst;
    end else begin
      rdata[0] = up;
      rdata[1] = timeout;
    end
  end

  // reserved write bits
  generate
    if (DATA_W > MODE_TOP + 1) begin : g_wide
      logic unused_rsvd;
      assign unused_rsvd = ^{wdata[B_LCK_LSB-1:B_RSTN+1], wdata[DATA_W-1:MODE_TOP+1]};
    end else begin : g_exact
      logic unused_rsvd;
      assign unused_rsvd = ^wdata[B_LCK_LSB-1:B_RSTN+1];
    end
  endgenerate
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int GAP_US       = 5,
  parameter int LOCK_US      = 50
) (
  input  logic      clk,
  input  logic      rst_n,
  input  mode_cfg_t cfg,
  input  logic      sw_on,
  input  logic      sw_off,
  input  logic      vote_req,
  input  logic      pll_lock,
  output logic      outen,
  output logic      bypass_n,
  output logic      reset_n,
  output logic      up
);
  localparam int MAX_A   = (GAP_US > LOCK_US) ? GAP_US : LOCK_US;
  localparam int MAX_US  = (MAX_A > FLD_MAX) ? MAX_A : FLD_MAX;
  localparam int MAX_CYC = MAX_US * TICKS_PER_US;
  localparam int CW      = $clog2(MAX_CYC + 1);

  function automatic logic [CW-1:0] span(input int unsigned us);
    int unsigned p;
    p = us * int'(TICKS_PER_US);
    if (p == 0) p = 1;
    return CW'(p);
  endfunction

  seq_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  gap_tgt, lock_tgt;
  logic [CW:0]    cnt_inc;
  logic           gap_done, wait_done;
  logic           vote_run, vote_stop;

  always_comb begin
    if (cfg.ven) begin
      gap_tgt  = span(int'(cfg.bias));
      lock_tgt = span(int'(cfg.lock));
    end else begin
      gap_tgt  = span(GAP_US);
      lock_tgt = span(LOCK_US);
    end
  end

  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign gap_done  = cnt_inc >= {1'b0, gap_tgt};
  assign wait_done = cnt_inc >= {1'b0, lock_tgt};
  assign vote_run  = cfg.ven && !cfg.vrst && vote_req;
  assign vote_stop = cfg.ven && !vote_run;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (sw_off) begin
      st_d  = SEQ_OFF;
      cnt_d = '0;
    end else if (sw_on && st_q == SEQ_OFF) begin
      st_d  = SEQ_BYPASS;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SEQ_OFF: begin
          cnt_d = '0;
          if (vote_run) st_d = SEQ_BYPASS;
        end
        SEQ_BYPASS: begin
          if (vote_stop) begin
            st_d  = SEQ_OFF;
            cnt_d = '0;
          end else if (gap_done) begin
            st_d  = SEQ_RELEASE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[CW-1:0];
          end
        end
        SEQ_RELEASE: begin
          if (vote_stop) begin
            st_d  = SEQ_OFF;
            cnt_d = '0;
          end else if (wait_done) begin
            if (pll_lock) begin
              st_d  = SEQ_ON;
              cnt_d = '0;
            end
          end else begin
            cnt_d = cnt_inc[CW-1:0];
          end
        end
        SEQ_ON: begin
          if (cfg.ven && cfg.vrst) st_d = SEQ_OFF;
          else if (vote_stop)      st_d = SEQ_DRAIN;
        end
        SEQ_DRAIN: st_d = SEQ_OFF;
        default:   st_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    outen    = 1'b0;
    bypass_n = 1'b0;
    reset_n  = 1'b0;
    unique case (st_q)
      SEQ_BYPASS:  bypass_n = 1'b1;
      SEQ_RELEASE: begin bypass_n = 1'b1; reset_n = 1'b1; end
      SEQ_ON:      begin bypass_n = 1'b1; reset_n = 1'b1; outen = 1'b1; end
      SEQ_DRAIN:   begin bypass_n = 1'b1; reset_n = 1'b1; end
      default:     ;
    endcase
  end
  assign up = (st_q == SEQ_ON);

  // cycles spent out of bypass with reset still held
  logic [CW:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                age_q <= '0;
    else if (!bypass_n)        age_q <= '0;
    else if (!reset_n && age_q != '1) age_q <= age_q + 1'b1;
  end

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reset_n) && !cfg.ven) |-> (age_q >= {1'b0, gap_tgt}));

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outen) |-> $past(pll_lock));

  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outen) |-> ($past(reset_n) && $past(bypass_n)));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ON && cfg.ven && !cfg.vrst && !vote_req && !sw_off && !sw_on)
      |=> (!outen && reset_n && bypass_n));
endmodule

// File: rtl/pll_seq_vote_watch.sv
module pll_seq_vote_watch #(
  parameter int WIN_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic up,
  output logic timeout
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else if (up) begin
      cnt_q <= '0;
    end else if (!timeout) begin
      if (cnt_q == WW'(WIN_CYC - 1)) timeout <= 1'b1;
      else                           cnt_q   <= cnt_q + 1'b1;
    end
  end

  assert_to_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !timeout);
endmodule

// File: rtl/pll_pwrup_seq.sv
module pll_pwrup_seq
  import pll_seq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int TICKS_PER_US = 4,
  parameter int GAP_US       = 5,
  parameter int LOCK_US      = 50,
  parameter int POLL_LIMIT   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vote_req,
  input  logic              pll_lock,
  output logic              pll_outen,
  output logic              pll_bypass_n,
  output logic              pll_reset_n,
  output logic              pll_up,
  output logic              vote_timeout
);
  localparam int WIN_CYC = POLL_LIMIT * TICKS_PER_US;

  mode_cfg_t cfg;
  logic      sw_on, sw_off;
  logic      armed;

  pll_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk, .rst_n,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .outen(pll_outen), .bypass_n(pll_bypass_n), .reset_n(pll_reset_n),
    .up(pll_up), .timeout(vote_timeout),
    .cfg, .sw_on, .sw_off, .rdata(reg_rdata)
  );

  pll_seq_fsm #(
    .TICKS_PER_US(TICKS_PER_US), .GAP_US(GAP_US), .LOCK_US(LOCK_US)
  ) u_fsm (
    .clk, .rst_n, .cfg, .sw_on, .sw_off, .vote_req, .pll_lock,
    .outen(pll_outen), .bypass_n(pll_bypass_n), .reset_n(pll_reset_n), .up(pll_up)
  );

  assign armed = cfg.ven && !cfg.vrst && vote_req;

  pll_seq_vote_watch #(.WIN_CYC(WIN_CYC)) u_watch (
    .clk, .rst_n, .armed, .up(pll_up), .timeout(vote_timeout)
  );

  assert_swoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |=> (!pll_outen && !pll_bypass_n && !pll_reset_n && !pll_up));

  assert_up_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_up && !sw_off && !cfg.ven) |=> pll_up);
endmodule

// File: tb/pll_pwrup_seq_bench.sv
module pll_pwrup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int TPU  = 4;
  localparam int GUS  = 5;
  localparam int LUS  = 50;
  localparam int POLL = 200;
  localparam int G    = GUS * TPU;
  localparam int L    = LUS * TPU;
  localparam int WIN  = POLL * TPU;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic          reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          vote_req;
  logic          pll_lock;
  logic          pll_outen, pll_bypass_n, pll_reset_n, pll_up, vote_timeout;

  pll_pwrup_seq #(
    .DATA_W(DW), .TICKS_PER_US(TPU), .GAP_US(GUS), .LOCK_US(LUS), .POLL_LIMIT(POLL)
  ) u_pll_pwrup_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .vote_req, .pll_lock, .pll_outen, .pll_bypass_n, .pll_reset_n,
    .pll_up, .vote_timeout
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  function automatic int span(int us);
    return (us == 0) ? 1 : us * TPU;
  endfunction

  function automatic int pins();
    return int'({pll_reset_n, pll_bypass_n, pll_outen});
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_addr  = 1'b0;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
    reg_addr = 1'b0;
  endtask

  task automatic measure(input int d, input int maxn, output int r_at, output int o_at);
    r_at = -1;
    o_at = -1;
    for (int n = 1; n <= maxn; n++) begin
      @(negedge clk);
      if (r_at < 0 && pll_reset_n) r_at = n;
      if (o_at < 0 && pll_outen)   o_at = n;
      if (n == d) pll_lock = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, r_at, o_at;
    void'($urandom(32'd7351));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    vote_req = 1'b0; pll_lock = 1'b1;
    step(4);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1", "pins", pins(), 0);
    chk("R1", "up", int'(pll_up), 0);
    chk("R1", "timeout", int'(vote_timeout), 0);
    rd(1'b0, v); chk("R1", "read mode", v, 0);
    rd(1'b1, v); chk("R1", "read status", v, 0);

    // R2 R3 software walk
    wr(32'h7);
    chk("R2", "bypass left", pins(), 2);
    step(G - 1); chk("R2", "reset held before gap", pins(), 2);
    step(1);     chk("R2", "reset released at gap", pins(), 6);
    step(L - 1); chk("R2", "output held before wait", pins(), 6);
    chk("R3", "up before output", int'(pll_up), 0);
    step(1);     chk("R2", "output on", pins(), 7);
    chk("R3", "up with output", int'(pll_up), 1);
    rd(1'b0, v); chk("R11", "read mode pins", v, 7);

    // R4 enable while on
    wr(32'h7); chk("R4", "no restart", pins(), 7);
    step(2);   chk("R4", "still on", pins(), 7);

    // R5 disable
    wr(32'h0);
    chk("R5", "all off", pins(), 0);
    chk("R3", "up cleared", int'(pll_up), 0);

    // R4 enable mid-sequence
    wr(32'h7); step(3); wr(32'h7);
    step(G - 5); chk("R4", "gap not shifted (before)", pins(), 2);
    step(1);     chk("R4", "gap not shifted (at)", pins(), 6);
    wr(32'h0);

    // R2 late lock
    pll_lock = 1'b0;
    wr(32'h7);
    step(G + L + 10); chk("R2", "waits for lock", pins(), 6);
    pll_lock = 1'b1;
    step(1); chk("R2", "on after lock", pins(), 7);
    wr(32'h0);

    // R5 collision with completion edge
    wr(32'h7);
    step(G + L - 1); chk("R5", "before completion", pins(), 6);
    wr(32'h0);
    chk("R5", "disable wins", pins(), 0);
    chk("R5", "up low", int'(pll_up), 0);
    step(1); chk("R5", "stays off", pins(), 0);

    // R6 vote ignored in software mode
    vote_req = 1'b1;
    step(30); chk("R6", "vote ignored", pins(), 0);
    vote_req = 1'b0;

    // R6 write with vote bit ignores control bits
    wr(32'h0010_4007);
    chk("R6", "vote-bit write", pins(), 0);
    step(5); chk("R6", "vote-bit write later", pins(), 0);

    // R7 vote walk: bias 1, lock 0
    vote_req = 1'b1;
    step(1); chk("R7", "vote bypass", pins(), 2);
    step(3); chk("R7", "vote gap", pins(), 2);
    step(1); chk("R7", "vote reset", pins(), 6);
    step(1); chk("R7", "vote on", pins(), 7);
    chk("R3", "vote up", int'(pll_up), 1);
    wr(32'h0010_4000); chk("R6", "sw disable ignored", pins(), 7);
    step(3); chk("R6", "sw disable ignored later", pins(), 7);

    // R8 drop
    vote_req = 1'b0;
    step(1); chk("R8", "output first", pins(), 6);
    chk("R8", "up with output", int'(pll_up), 0);
    step(1); chk("R8", "rest off", pins(), 0);

    vote_req = 1'b1;
    step(3); chk("R8", "early walk", pins(), 2);
    vote_req = 1'b0;
    step(1); chk("R8", "early drop", pins(), 0);

    // R9 vote hold
    wr(32'h0030_4000);
    vote_req = 1'b1;
    step(30); chk("R9", "held idle", pins(), 0);
    wr(32'h0010_4000); chk("R9", "release lands one edge late", pins(), 0);
    step(1); chk("R9", "starts", pins(), 2);
    step(1);
    wr(32'h0030_4000); chk("R9", "hold lands one edge late", pins(), 2);
    step(1); chk("R9", "hold stops walk", pins(), 0);
    vote_req = 1'b0;

    // R10 timeout
    wr(32'h0010_4000);
    pll_lock = 1'b0;
    vote_req = 1'b1;
    step(WIN - 1); chk("R10", "no timeout yet", int'(vote_timeout), 0);
    step(1);       chk("R10", "timeout", int'(vote_timeout), 1);
    rd(1'b1, v);   chk("R11", "read status", v, 2);
    vote_req = 1'b0;
    step(1); chk("R10", "timeout clears", int'(vote_timeout), 0);
    pll_lock = 1'b1;
    step(1);

    // R11 field readback, R4 odd control pattern
    wr(32'h0);
    wr(32'h0005_6A03);
    chk("R4", "odd pattern no pin change", pins(), 0);
    rd(1'b0, v); chk("R11", "read fields", v, 32'h0005_6A00);
    wr(32'h0);

    // random mix
    for (int it = 0; it < 16; it++) begin
      if ($urandom % 2 == 0) begin
        int d, exp_o;
        d = int'($urandom % 300);
        pll_lock = (d == 0);
        wr(32'h7);
        measure(d, G + L + 320, r_at, o_at);
        exp_o = (d + 1 > G + L) ? d + 1 : G + L;
        chk("R2", "random sw reset edge", r_at, G);
        chk("R2", "random sw output edge", o_at, exp_o);
        wr(32'h0);
        pll_lock = 1'b1;
      end else begin
        int b, c;
        b = int'($urandom % 8);
        c = int'($urandom % 8);
        wr((32'd1 << 20) | (32'(b) << 14) | (32'(c) << 8));
        pll_lock = 1'b1;
        vote_req = 1'b1;
        measure(-1, 200, r_at, o_at);
        chk("R7", "random vote reset edge", r_at, span(b) + 1);
        chk("R7", "random vote output edge", o_at, span(b) + span(c) + 1);
        vote_req = 1'b0;
        step(2); chk("R8", "random vote drop", pins(), 0);
        wr(32'h0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule